// File: doc/BRIEF.md
# Link Self-Test Receive Pattern Checker

This block sits after the character decoder of a serial link receiver and checks a self-test stream. The stream carries one character per byte clock. Each character is a decoded byte plus a special/data flag and a code-violation flag. Self-test is enabled by holding an active-low enable input low. The checker then waits for a start character, the special character 0xBC. Once it has seen that character it arms, drops its ready output and regenerates the expected loop on its own. It compares every received character against that loop and raises a one-cycle error flag for each character that does not match.

A loop is 256 byte times. It holds 255 data bytes from an 8-bit maximal-length LFSR, then a special marker character, 0x3C. Four positions in each loop carry deliberate code violations. At those positions the received data is not compared, and the error flag follows the received violation flag. A healthy link therefore still pulses the error flag there, which proves that the violation path works. The ready output pulses high once per completed loop, so an external counter can follow progress. While checking, the data outputs show the expected character instead of the received one. While self-test is enabled, the block also forces the receiver onto the decoded path, even when the receiver is set to raw bypass.

Top module: `bistLinkChecker`

## Requirements
- R1: After reset, `rdy` is 1 and `errFlag` is 0, and `dataOut`/`specialOut` follow `rxData`/`rxSpecial`.
- R2: While enabled but not armed, `rdy` stays 1 and `errFlag` stays 0 for every character other than the start character. The start character is `rxSpecial`=1, `rxData`=0xBC and `rxViol`=0.
- R3: When the start character is sampled with `bistEnN`=0, `rdy` is 0 from the next cycle onward. The next character is compared as loop position 0.
- R4: Positions 0 to 254 expect a data character (special=0) whose byte is the LFSR state. The LFSR starts at 0x01 and steps as next = {s[6:0], s[7]^s[5]^s[4]^s[3]}. Position 255 expects special 0x3C. The loop then restarts at position 0 with the LFSR reseeded to 0x01.
- R5: While armed and enabled, `dataOut`/`specialOut` show the expected character for the current byte time.
- R6: At a position that is not a violation slot, a character with a different byte, a different special flag, or `rxViol`=1 sets `errFlag` for exactly the following cycle. A matching character with `rxViol`=0 leaves it at 0.
- R7: The violation slots are the data positions whose low six bits equal 32 (32, 96, 160, 224). At a slot the received byte and flag are ignored, and `errFlag` in the following cycle equals the received `rxViol`.
- R8: `rdy` is 1 for exactly the one cycle after the marker position is sampled, and this happens once per loop whether or not the marker matched.
- R9: When `bistEnN`=1 is sampled, the block disarms at that edge. The character at that edge is not compared. `rdy` returns to 1, `errFlag` to 0, and outputs pass the received data through. Re-enabling requires a new start character.
- R10: `useDecoded` is 1 when `bypassMode` is 0 or `bistEnN` is 0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| bistEnN | input | 1 | Self-test enable, active low |
| bypassMode | input | 1 | Receiver is configured for raw bypass |
| rxData | input | 8 | Decoded received byte |
| rxSpecial | input | 1 | Received character is a special character |
| rxViol | input | 1 | Decoder found a code violation |
| rdy | output | 1 | High when not armed; one-cycle high pulse per completed loop |
| errFlag | output | 1 | One-cycle flag per mismatching character |
| dataOut | output | 8 | Expected byte while checking, otherwise received byte |
| specialOut | output | 1 | Expected special flag while checking, otherwise received flag |
| useDecoded | output | 1 | Selects the decoded receive path |

## Verification
The assertions check the cycle-level rules on every cycle:
- no error flag unless the block was enabled in the previous cycle;
- a full return to idle after an edge where the enable was high;
- a loop pulse lasting exactly one cycle;
- arming only right after a start character.

Only the bench scenarios can show that the LFSR sequence, marker, violation-slot positions and loop reseeding are correct. The same holds for the rule that a fault is flagged only at the byte it hits and that data at a violation slot is ignored. These need a model of the whole loop.

// File: rtl/bistChkPkg.sv
package bistChkPkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic check;       // compare this byte time
    logic seedLoad;    // reload generator with seed
    logic advance;     // step generator
    logic markerSlot;  // loop position expects the marker
    logic violSlot;    // loop position carries a deliberate violation
  } ctlStrobes_t;
endpackage

// File: rtl/bistLoopCtrl.sv
module bistLoopCtrl
  import bistChkPkg::*;
#(
  parameter int SLOT_SHIFT  = 6,
  parameter int SLOT_OFFSET = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bistEnN,
  input  logic        initHit,
  output ctlStrobes_t strobes,
  output logic        armed,
  output logic        loopPulse
);
  localparam logic [SLOT_SHIFT-1:0] SLOT_HIT = SLOT_OFFSET[SLOT_SHIFT-1:0];

  byte_t pos;
  logic  atEnd;
  logic  checkNow;

  assign atEnd    = (pos == '1);
  assign checkNow = armed & ~bistEnN;

  always_ff @(posedge clk) begin
    if (!rstN || bistEnN) begin
      armed <= 1'b0;
    end else if (!armed && initHit) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !checkNow) begin
      pos <= '0;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loopPulse <= 1'b0;
    end else begin
      loopPulse <= checkNow & atEnd;
    end
  end

  always_comb begin
    strobes.check      = checkNow;
    strobes.advance    = checkNow & ~atEnd;
    strobes.seedLoad   = ~checkNow | atEnd;
    strobes.markerSlot = atEnd;
    strobes.violSlot   = ~atEnd & (pos[SLOT_SHIFT-1:0] == SLOT_HIT);
  end
endmodule

// File: rtl/bistPatternPath.sv
module bistPatternPath
  import bistChkPkg::*;
#(
  parameter byte_t SEED      = 8'h01,
  parameter byte_t TAPS      = 8'hB8,
  parameter byte_t INIT_CODE = 8'hBC,
  parameter byte_t MARK_CODE = 8'h3C
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  byte_t       rxData,
  input  logic        rxSpecial,
  input  logic        rxViol,
  output logic        initHit,
  output logic        errFlag,
  output byte_t       dataOut,
  output logic        specialOut
);
  byte_t lfsr;
  byte_t expData;
  logic  expSpecial;
  logic  charDiff;
  logic  missRaw;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.seedLoad) begin
      lfsr <= SEED;
    end else if (strobes.advance) begin
      lfsr <= {lfsr[BYTE_W-2:0], ^(lfsr & TAPS)};
    end
  end

  assign expData    = strobes.markerSlot ? MARK_CODE : lfsr;
  assign expSpecial = strobes.markerSlot;
  assign charDiff   = (rxData != expData) | (rxSpecial != expSpecial);
  assign missRaw    = strobes.violSlot ? rxViol : (rxViol | charDiff);
  assign initHit    = rxSpecial & ~rxViol & (rxData == INIT_CODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else begin
      errFlag <= strobes.check & missRaw;
    end
  end

  assign dataOut    = strobes.check ? expData : rxData;
  assign specialOut = strobes.check ? expSpecial : rxSpecial;
endmodule

// File: rtl/bistLinkChecker.sv
module bistLinkChecker
  import bistChkPkg::*;
#(
  parameter byte_t SEED        = 8'h01,
  parameter byte_t TAPS        = 8'hB8,
  parameter byte_t INIT_CODE   = 8'hBC,
  parameter byte_t MARK_CODE   = 8'h3C,
  parameter int    SLOT_SHIFT  = 6,
  parameter int    SLOT_OFFSET = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bistEnN,
  input  logic       bypassMode,
  input  logic [7:0] rxData,
  input  logic       rxSpecial,
  input  logic       rxViol,
  output logic       rdy,
  output logic       errFlag,
  output logic [7:0] dataOut,
  output logic       specialOut,
  output logic       useDecoded
);
  ctlStrobes_t strobes;
  logic        armed;
  logic        loopPulse;
  logic        initHit;

  bistLoopCtrl #(
    .SLOT_SHIFT (SLOT_SHIFT),
    .SLOT_OFFSET(SLOT_OFFSET)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .bistEnN  (bistEnN),
    .initHit  (initHit),
    .strobes  (strobes),
    .armed    (armed),
    .loopPulse(loopPulse)
  );

  bistPatternPath #(
    .SEED     (SEED),
    .TAPS     (TAPS),
    .INIT_CODE(INIT_CODE),
    .MARK_CODE(MARK_CODE)
  ) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rxData    (rxData),
    .rxSpecial (rxSpecial),
    .rxViol    (rxViol),
    .initHit   (initHit),
    .errFlag   (errFlag),
    .dataOut   (dataOut),
    .specialOut(specialOut)
  );

  assign rdy        = ~armed | loopPulse;
  assign useDecoded = ~bypassMode | ~bistEnN;
endmodule

// File: rtl/bistLinkChecker_sva.sv
module bistLinkChecker_sva #(
  parameter logic [7:0] INIT_CODE = 8'hBC
) (
  input logic       clk,
  input logic       rstN,
  input logic       bistEnN,
  input logic [7:0] rxData,
  input logic       rxSpecial,
  input logic       rxViol,
  input logic       rdy,
  input logic       errFlag,
  input logic [7:0] dataOut,
  input logic       specialOut
);
  // R6: a flagged byte must have been sampled while enabled
  assert_err_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(!bistEnN));

  // R9: an edge with the enable high leaves the block idle and passing data through
  assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(bistEnN) |-> (rdy && !errFlag && dataOut == rxData && specialOut == rxSpecial));

  // R8: the loop pulse lasts one cycle while enable stays low
  assert_loop_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdy && !$past(rdy) && !bistEnN && !$past(bistEnN)) |=> !rdy);

  // R3: leaving idle happens only right after a start character
  assert_arm_on_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rdy) && $past(rdy, 2)) |->
      $past(rxSpecial && !rxViol && rxData == INIT_CODE && !bistEnN));
endmodule

bind bistLinkChecker bistLinkChecker_sva #(
  .INIT_CODE(INIT_CODE)
) sva_i (
  .clk       (clk),
  .rstN      (rstN),
  .bistEnN   (bistEnN),
  .rxData    (rxData),
  .rxSpecial (rxSpecial),
  .rxViol    (rxViol),
  .rdy       (rdy),
  .errFlag   (errFlag),
  .dataOut   (dataOut),
  .specialOut(specialOut)
);

// File: tb/bistLinkChecker_tb_top.sv
`timescale 1ns/1ps
module bistLinkChecker_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bistEnN = 1'b1;
  logic       bypassMode = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic       rxSpecial = 1'b0;
  logic       rxViol = 1'b0;
  logic       rdy, errFlag, specialOut, useDecoded;
  logic [7:0] dataOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bistLinkChecker dut_i (
    .clk(clk), .rstN(rstN), .bistEnN(bistEnN), .bypassMode(bypassMode),
    .rxData(rxData), .rxSpecial(rxSpecial), .rxViol(rxViol),
    .rdy(rdy), .errFlag(errFlag), .dataOut(dataOut),
    .specialOut(specialOut), .useDecoded(useDecoded)
  );

  function automatic logic [7:0] lfsrNext(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input logic s, input logic v);
    rxData = d; rxSpecial = s; rxViol = v;
    @(posedge clk); #1;
  endtask

  task automatic testReset();
    rstN = 1'b0; bistEnN = 1'b1;
    rxData = 8'h5A; rxSpecial = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "rdy in reset", rdy, 1);
    check("R1", "errFlag in reset", errFlag, 0);
    check("R1", "dataOut passthrough", dataOut, 8'h5A);
    check("R1", "specialOut passthrough", specialOut, 1);
    rstN = 1'b1;
    sendByte(8'h33, 1'b0, 1'b0);
    check("R1", "rdy after reset", rdy, 1);
    check("R1", "errFlag after reset", errFlag, 0);
    check("R1", "dataOut follows rx", dataOut, 8'h33);
  endtask

  task automatic testIgnore();
    bistEnN = 1'b0;
    sendByte(8'hBC, 1'b0, 1'b0);
    check("R2", "rdy after 0xBC data", rdy, 1);
    check("R2", "err after 0xBC data", errFlag, 0);
    sendByte(8'hBC, 1'b1, 1'b1);
    check("R2", "rdy after 0xBC with violation", rdy, 1);
    check("R2", "err after 0xBC with violation", errFlag, 0);
    sendByte(8'h3C, 1'b1, 1'b0);
    check("R2", "rdy after marker char", rdy, 1);
    sendByte(8'h01, 1'b0, 1'b1);
    check("R2", "rdy after seed byte", rdy, 1);
    check("R2", "err after violating byte", errFlag, 0);
  endtask

  task automatic arm();
    bistEnN = 1'b0;
    sendByte(8'hBC, 1'b1, 1'b0);
    check("R3", "rdy low after start char", rdy, 0);
    check("R3", "err after start char", errFlag, 0);
  endtask

  // one full loop; fault positions of -1 mean none
  task automatic runLoop(input int flipPos, input int specPos, input int violPos,
                         input int garbPos, input int dropPos);
    logic [7:0] l = 8'h01;
    for (int p = 0; p < 256; p++) begin
      logic       isMark = (p == 255);
      logic       isSlot = !isMark && ((p % 64) == 32);
      logic [7:0] expD = isMark ? 8'h3C : l;
      logic       expS = isMark;
      logic [7:0] d = expD;
      logic       s = expS;
      logic       v = isSlot;
      logic       expErr;
      check("R5", "expected byte shown", dataOut, expD);
      check("R4", "expected special shown", specialOut, expS);
      if (p == dropPos)  v = 1'b0;
      if (p == flipPos)  d = d ^ 8'h10;
      if (p == specPos)  s = ~s;
      if (p == violPos)  v = 1'b1;
      if (p == garbPos)  d = ~d;
      expErr = isSlot ? v : (v | (d != expD) | (s != expS));
      sendByte(d, s, v);
      if (isSlot) check("R7", $sformatf("errFlag at slot %0d", p), errFlag, expErr);
      else        check("R6", $sformatf("errFlag at pos %0d", p), errFlag, expErr);
      check("R8", $sformatf("rdy after pos %0d", p), rdy, isMark);
      if (!isMark) l = lfsrNext(l);
    end
  endtask

  task automatic testLoops();
    arm();
    runLoop(-1, -1, -1, -1, -1);
    runLoop(10, 200, 77, 96, 160);
    runLoop(-1, -1, -1, -1, 224);
    runLoop(255, -1, -1, 32, -1);
  endtask

  task automatic testDisable();
    logic [7:0] l = 8'h01;
    for (int p = 0; p < 10; p++) begin
      sendByte(l, 1'b0, 1'b0);
      l = lfsrNext(l);
    end
    check("R9", "still armed mid-loop", rdy, 0);
    bistEnN = 1'b1;
    sendByte(8'hEE, 1'b1, 1'b1);
    check("R9", "rdy after disable", rdy, 1);
    check("R9", "errFlag after disable", errFlag, 0);
    check("R9", "dataOut passthrough", dataOut, 8'hEE);
    bistEnN = 1'b0;
    sendByte(8'h01, 1'b0, 1'b0);
    check("R9", "no arming without start char", rdy, 1);
    check("R9", "no error while unarmed", errFlag, 0);
    arm();
    runLoop(-1, -1, -1, -1, -1);
    bistEnN = 1'b1;
    sendByte(8'h00, 1'b0, 1'b0);
    check("R9", "idle after final disable", rdy, 1);
  endtask

  task automatic testBypass();
    bypassMode = 1'b1; bistEnN = 1'b1; #1;
    check("R10", "bypass, disabled", useDecoded, 0);
    bistEnN = 1'b0; #1;
    check("R10", "bypass, enabled", useDecoded, 1);
    bypassMode = 1'b0; bistEnN = 1'b1; #1;
    check("R10", "decoded, disabled", useDecoded, 1);
    bistEnN = 1'b0; #1;
    check("R10", "decoded, enabled", useDecoded, 1);
    bistEnN = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    testReset();
    testIgnore();
    testLoops();
    testDisable();
    testBypass();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule